// File: doc/BRIEF.md
# Sector Scan Comparator

This block runs the data-matching part of a disk scan. The host supplies a first sector number, an end-of-track sector number, a stride of one or two, and a five-bit scan command code. The block then takes pairs of bytes. One byte of each pair comes from the medium and the other comes from the host. Every pair is judged against the selected condition: equal, disk at or below host, or disk at or above host. A byte of FFh on either side is a wildcard and always passes.

A sector is a fixed number of byte pairs. The first sector whose pairs all pass ends the scan as a hit. A sector that fails moves the scan on by the stride. The scan ends as not satisfied when the next sector would lie past the end-of-track number, or when a terminal count arrives. An index pulse during a scan aborts it. The sector number on the output is the one in progress, and after the scan it is the last one processed, so the caller can place it in its result bytes. Reading the medium and checking CRCs happen elsewhere.

Top module: `sector_scan_cmp`

## Requirements
- R1: After reset, busy, done, scan-hit, not-satisfied and abort are all 0, and the sector output is 0.
- R2: The comparison is chosen by bits 3 and 2 of the command code, and its other bits are ignored. Bit 3 = 0 selects equality. Bit 3 = 1 with bit 2 = 0 passes when disk ≤ host. Bit 3 = 1 with bit 2 = 1 passes when disk ≥ host. So 11h is equal, 19h is low-or-equal and 1Dh is high-or-equal.
- R3: A pair in which either byte is FFh passes under every condition and counts as an exact match.
- R4: A pair is taken only in a cycle where both valid strobes are high while busy. A cycle with only one strobe high changes nothing. A sector is SECTOR_BYTES taken pairs.
- R5: When every pair of a sector passes, the scan ends as a hit. Scan-hit is 1 only if every pair of that sector was an exact match. Otherwise all three result flags stay 0.
- R6: After a failing sector, the sector output becomes the current number plus 1 (stride input 0) or plus 2 (stride input 1). The new value is visible in the cycle after the sector's last pair.
- R7: The scan ends with not-satisfied set when a sector fails and the current number plus the stride exceeds the end-of-track number. The sector output keeps the failing sector's number.
- R8: If terminal count comes with a pair, that pair is still judged before the scan stops. The result is a hit only if that pair completes a passing sector, and not-satisfied otherwise. Terminal count with no pair ends the scan as not-satisfied.
- R9: An index pulse while busy ends the scan with abort set and scan-hit and not-satisfied clear. Any pair in that same cycle is ignored.
- R10: When start is accepted, busy is 1 in the next cycle, the flags are clear and the sector output equals the first sector. The cycle after the final event shows done for exactly one cycle, with busy 0. The flags and the sector output then hold until the next start.
- R11: A start while busy is ignored. The scan in progress and its sector number are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a scan (taken when idle) |
| cmd_code_i | input | 5 | Scan command code; bits 3:2 choose the condition |
| first_sector_i | input | SECT_W | First sector number |
| eot_sector_i | input | SECT_W | End-of-track sector number |
| stride_two_i | input | 1 | 0: stride 1, 1: stride 2 |
| disk_vld_i | input | 1 | Disk byte valid |
| disk_byte_i | input | 8 | Byte read from the medium |
| host_vld_i | input | 1 | Host byte valid |
| host_byte_i | input | 8 | Byte supplied by the host |
| tc_i | input | 1 | Terminal count |
| index_i | input | 1 | Index pulse |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| scan_hit_o | output | 1 | Hit with all pairs exact |
| scan_nosat_o | output | 1 | Scan ended without a hit |
| abort_o | output | 1 | Scan aborted by an index pulse |
| sector_o | output | SECT_W | Current or last processed sector number |

## Verification
Faults in the pair accumulator show up as a wrong result when the sector's last pair is taken. A pass that leaks across a sector boundary, or a byte counter off by one, moves done by a whole pair or turns a miss into a hit. A wrong stride or end-of-track decision shows on the sector output in the cycle after a failing sector ends, which is one to three sectors before the scan would finish. A faulty priority between the index pulse, terminal count and the pairs is visible at the single edge where they coincide.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [7:0]  WILDCARD = 8'hFF;

    typedef enum logic [1:0] {
        MODE_EQ = 2'd0,
        MODE_LE = 2'd1,
        MODE_GE = 2'd2
    } scan_mode_e;

    typedef enum logic [1:0] {
        END_NONE  = 2'd0,
        END_HIT   = 2'd1,
        END_NOSAT = 2'd2,
        END_ABORT = 2'd3
    } scan_end_e;

    typedef struct packed {
        logic pass;
        logic exact;
    } pair_verdict_t;

    typedef struct packed {
        logic hit;
        logic nosat;
        logic abort;
    } scan_flags_t;

    function automatic scan_mode_e mode_from_code(input logic [4:0] code);
        if (!code[3])     return MODE_EQ;
        else if (code[2]) return MODE_GE;
        else              return MODE_LE;
    endfunction

    function automatic pair_verdict_t judge_pair(input scan_mode_e mode,
                                                 input logic [7:0] d,
                                                 input logic [7:0] h);
        pair_verdict_t v;
        logic wild;
        wild    = (d == WILDCARD) || (h == WILDCARD);
        v.exact = wild || (d == h);
        case (mode)
            MODE_LE: v.pass = wild || (d <= h);
            MODE_GE: v.pass = wild || (d >= h);
            default: v.pass = v.exact;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/scan_pair_judge.sv
module scan_pair_judge
    import scan_pkg::*;
(
    input  scan_mode_e     mode,
    input  logic [7:0]     disk_byte,
    input  logic [7:0]     host_byte,
    output pair_verdict_t  verdict
);
    always_comb verdict = judge_pair(mode, disk_byte, host_byte);
endmodule

// File: rtl/scan_sector_acc.sv
module scan_sector_acc
    import scan_pkg::*;
#(
    parameter int SECTOR_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          take,
    input  pair_verdict_t verdict,
    output logic          sect_last,
    output logic          sect_pass,
    output logic          sect_exact
);
    localparam int CNT_W = (SECTOR_BYTES > 1) ? $clog2(SECTOR_BYTES) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SECTOR_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             pass_q;
    logic             exact_q;

    assign sect_last  = (cnt_q == LAST_IDX);
    assign sect_pass  = pass_q  & verdict.pass;
    assign sect_exact = exact_q & verdict.exact;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q   <= '0;
            pass_q  <= 1'b1;
            exact_q <= 1'b1;
        end else if (take) begin
            if (sect_last) begin
                cnt_q   <= '0;
                pass_q  <= 1'b1;
                exact_q <= 1'b1;
            end else begin
                cnt_q   <= cnt_q + CNT_W'(1);
                pass_q  <= sect_pass;
                exact_q <= sect_exact;
            end
        end
    end
endmodule

// File: rtl/scan_sector_step.sv
module scan_sector_step #(
    parameter int SECT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SECT_W-1:0] first_sector,
    input  logic [SECT_W-1:0] eot_sector,
    input  logic              stride_two,
    input  logic              advance,
    output logic [SECT_W-1:0] cur_sector,
    output logic              track_end
);
    localparam int EXT_W = SECT_W + 1;

    logic [SECT_W-1:0] cur_q;
    logic [SECT_W-1:0] eot_q;
    logic              two_q;
    logic [EXT_W-1:0]  next_ext;

    assign next_ext   = {1'b0, cur_q} + (two_q ? EXT_W'(2) : EXT_W'(1));
    assign track_end  = next_ext > {1'b0, eot_q};
    assign cur_sector = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            eot_q <= '0;
            two_q <= 1'b0;
        end else if (load) begin
            cur_q <= first_sector;
            eot_q <= eot_sector;
            two_q <= stride_two;
        end else if (advance) begin
            cur_q <= next_ext[SECT_W-1:0];
        end
    end
endmodule

// File: rtl/sector_scan_cmp.sv
module sector_scan_cmp
    import scan_pkg::*;
#(
    parameter int SECT_W       = 8,
    parameter int SECTOR_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [4:0]        cmd_code_i,
    input  logic [SECT_W-1:0] first_sector_i,
    input  logic [SECT_W-1:0] eot_sector_i,
    input  logic              stride_two_i,
    input  logic              disk_vld_i,
    input  logic [7:0]        disk_byte_i,
    input  logic              host_vld_i,
    input  logic [7:0]        host_byte_i,
    input  logic              tc_i,
    input  logic              index_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              scan_hit_o,
    output logic              scan_nosat_o,
    output logic              abort_o,
    output logic [SECT_W-1:0] sector_o
);
    logic          busy_q;
    logic          done_q;
    scan_flags_t   flags_q;
    scan_mode_e    mode_q;
    pair_verdict_t verdict;
    logic          accept_start;
    logic          pair_take;
    logic          sect_last;
    logic          sect_pass;
    logic          sect_exact;
    logic          track_end;
    logic          advance;
    scan_end_e     end_kind;

    assign accept_start = start_i & ~busy_q;
    assign pair_take    = busy_q & disk_vld_i & host_vld_i & ~index_i;

    scan_pair_judge u_judge (
        .mode      (mode_q),
        .disk_byte (disk_byte_i),
        .host_byte (host_byte_i),
        .verdict   (verdict)
    );

    scan_sector_acc #(.SECTOR_BYTES(SECTOR_BYTES)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .clear      (accept_start),
        .take       (pair_take),
        .verdict    (verdict),
        .sect_last  (sect_last),
        .sect_pass  (sect_pass),
        .sect_exact (sect_exact)
    );

    scan_sector_step #(.SECT_W(SECT_W)) u_step (
        .clk          (clk),
        .rst          (rst),
        .load         (accept_start),
        .first_sector (first_sector_i),
        .eot_sector   (eot_sector_i),
        .stride_two   (stride_two_i),
        .advance      (advance),
        .cur_sector   (sector_o),
        .track_end    (track_end)
    );

    // Priority: index pulse, then the pair (with terminal count after it), then bare terminal count.
    always_comb begin
        end_kind = END_NONE;
        advance  = 1'b0;
        if (busy_q) begin
            if (index_i) begin
                end_kind = END_ABORT;
            end else if (pair_take) begin
                if (sect_last) begin
                    if (sect_pass)                end_kind = END_HIT;
                    else if (tc_i || track_end)   end_kind = END_NOSAT;
                    else                          advance  = 1'b1;
                end else if (tc_i) begin
                    end_kind = END_NOSAT;
                end
            end else if (tc_i) begin
                end_kind = END_NOSAT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            flags_q <= '0;
            mode_q  <= MODE_EQ;
        end else begin
            done_q <= (end_kind != END_NONE);
            if (accept_start) begin
                busy_q  <= 1'b1;
                flags_q <= '0;
                mode_q  <= mode_from_code(cmd_code_i);
            end else if (end_kind != END_NONE) begin
                busy_q <= 1'b0;
                case (end_kind)
                    END_HIT:   flags_q <= '{hit: sect_exact, nosat: 1'b0, abort: 1'b0};
                    END_NOSAT: flags_q <= '{hit: 1'b0, nosat: 1'b1, abort: 1'b0};
                    default:   flags_q <= '{hit: 1'b0, nosat: 1'b0, abort: 1'b1};
                endcase
            end
        end
    end

    assign busy_o       = busy_q;
    assign done_o       = done_q;
    assign scan_hit_o   = flags_q.hit;
    assign scan_nosat_o = flags_q.nosat;
    assign abort_o      = flags_q.abort;
endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int SECT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              index_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              scan_hit_o,
    input logic              scan_nosat_o,
    input logic              abort_o,
    input logic [SECT_W-1:0] sector_o
);
    localparam int EXT_W = SECT_W + 1;

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    assert_flags_clear_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!scan_hit_o && !scan_nosat_o && !abort_o));

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !done_o) |-> $stable({scan_hit_o, scan_nosat_o, abort_o, sector_o}));

    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({scan_hit_o, scan_nosat_o, abort_o}));

    assert_index_abort_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && index_i) |=> (done_o && abort_o));

    assert_stride_R6: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o)) |->
            (({1'b0, sector_o} == {1'b0, $past(sector_o)}) ||
             ({1'b0, sector_o} == {1'b0, $past(sector_o)} + EXT_W'(1)) ||
             ({1'b0, sector_o} == {1'b0, $past(sector_o)} + EXT_W'(2))));
endmodule

bind sector_scan_cmp scan_checker #(.SECT_W(SECT_W)) u_scan_checker (
    .clk          (clk),
    .rst          (rst),
    .index_i      (index_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .scan_hit_o   (scan_hit_o),
    .scan_nosat_o (scan_nosat_o),
    .abort_o      (abort_o),
    .sector_o     (sector_o)
);

// File: tb/sector_scan_cmp_test.sv
module sector_scan_cmp_test;
    localparam int SW = 8;
    localparam int SB = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [4:0]    cmd_code_i = '0;
    logic [SW-1:0] first_sector_i = '0;
    logic [SW-1:0] eot_sector_i = '0;
    logic          stride_two_i = 1'b0;
    logic          disk_vld_i = 1'b0;
    logic [7:0]    disk_byte_i = '0;
    logic          host_vld_i = 1'b0;
    logic [7:0]    host_byte_i = '0;
    logic          tc_i = 1'b0;
    logic          index_i = 1'b0;
    logic          busy_o, done_o, scan_hit_o, scan_nosat_o, abort_o;
    logic [SW-1:0] sector_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sector_scan_cmp #(.SECT_W(SW), .SECTOR_BYTES(SB)) uut (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_code_i(cmd_code_i),
        .first_sector_i(first_sector_i), .eot_sector_i(eot_sector_i),
        .stride_two_i(stride_two_i), .disk_vld_i(disk_vld_i),
        .disk_byte_i(disk_byte_i), .host_vld_i(host_vld_i),
        .host_byte_i(host_byte_i), .tc_i(tc_i), .index_i(index_i),
        .busy_o(busy_o), .done_o(done_o), .scan_hit_o(scan_hit_o),
        .scan_nosat_o(scan_nosat_o), .abort_o(abort_o), .sector_o(sector_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 wildcard bytes appear through pattern kinds 3 and 4
    function automatic logic [7:0] gen_byte(input int seed, input int sect,
                                            input int b, input bit disk);
        int base;
        int pk;
        base = (sect * 29 + b * 7 + seed * 13) % 128;
        pk   = (seed + sect) % 6;
        case (pk)
            1: if (b == 2 && !disk) return 8'(base + 1);
            2: if (b == 2 && disk)  return 8'(base + 1);
            3: if (b == 2 && disk)  return 8'hFF;
            4: begin
                if (b == 3 && !disk) return 8'hFF;
                if (b == 1 && disk)  return 8'(base + 5);
            end
            5: begin
                if (b == 0 && disk)  return 8'(base + 1);
                if (b == 3 && !disk) return 8'(base + 1);
            end
            default: ;
        endcase
        return 8'(base);
    endfunction

    function automatic int code_mode(input logic [4:0] code);
        if (!code[3]) return 0;
        return code[2] ? 2 : 1;
    endfunction

    function automatic bit ref_pass(input int m, input logic [7:0] d, input logic [7:0] h);
        if (d == 8'hFF || h == 8'hFF) return 1'b1;
        if (m == 1) return d <= h;
        if (m == 2) return d >= h;
        return d == h;
    endfunction

    function automatic bit ref_exact(input logic [7:0] d, input logic [7:0] h);
        return (d == 8'hFF) || (h == 8'hFF) || (d == h);
    endfunction

    task automatic clear_inputs();
        start_i = 1'b0; disk_vld_i = 1'b0; host_vld_i = 1'b0;
        tc_i = 1'b0; index_i = 1'b0;
    endtask

    task automatic run_case(input logic [4:0] cmd, input int first, input int eot,
                            input bit two, input int seed, input int tc_pos,
                            input bit tc_alone, input int idx_pos, input bit probe,
                            input string tag);
        int  cur;
        int  n;
        int  ek;
        bit  fin;
        bit  hx;
        int  m;
        int  step;
        string rq;
        cur = first; n = 0; ek = 0; fin = 0; hx = 0;
        m = code_mode(cmd);
        step = two ? 2 : 1;
        cmd_code_i = cmd; first_sector_i = SW'(first); eot_sector_i = SW'(eot);
        stride_two_i = two; start_i = 1'b1;
        @(negedge clk); clear_inputs();
        check(busy_o == 1'b1 && int'(sector_o) == first &&
              !scan_hit_o && !scan_nosat_o && !abort_o,
              "R10", {tag, " start accepted sector"}, int'(sector_o), first);
        while (!fin) begin
            bit ap;
            bit ae;
            ap = 1'b1; ae = 1'b1;
            for (int b = 0; b < SB && !fin; b++) begin
                if (((n + seed) % 5) == 0) begin
                    disk_vld_i = (n % 2 == 0); host_vld_i = !(n % 2 == 0);
                    disk_byte_i = 8'h00; host_byte_i = 8'h55;
                    if (probe) begin start_i = 1'b1; first_sector_i = SW'(200); end
                    @(negedge clk); clear_inputs();
                    check(busy_o && !done_o && int'(sector_o) == cur,
                          probe ? "R11" : "R4", {tag, " one-sided or restart cycle"},
                          int'(sector_o), cur);
                end
                if (n == idx_pos) begin
                    index_i = 1'b1; disk_vld_i = 1'b1; host_vld_i = 1'b1;
                    disk_byte_i = 8'h10; host_byte_i = 8'h10;
                    @(negedge clk); clear_inputs();
                    ek = 3; fin = 1;
                end else if (tc_alone && n == tc_pos) begin
                    tc_i = 1'b1;
                    @(negedge clk); clear_inputs();
                    ek = 2; fin = 1;
                end else begin
                    logic [7:0] d;
                    logic [7:0] h;
                    bit tc;
                    d = gen_byte(seed, cur, b, 1'b1);
                    h = gen_byte(seed, cur, b, 1'b0);
                    tc = (n == tc_pos);
                    disk_vld_i = 1'b1; host_vld_i = 1'b1;
                    disk_byte_i = d; host_byte_i = h; tc_i = tc;
                    ap = ap & ref_pass(m, d, h);
                    ae = ae & ref_exact(d, h);
                    @(negedge clk); clear_inputs();
                    n++;
                    if (tc) begin
                        if (b == SB - 1 && ap) begin ek = 1; hx = ae; end
                        else ek = 2;
                        fin = 1;
                    end else if (b == SB - 1) begin
                        if (ap) begin ek = 1; hx = ae; fin = 1; end
                        else if (cur + step > eot) begin ek = 2; fin = 1; end
                        else begin
                            cur = cur + step;
                            check(busy_o && !done_o && int'(sector_o) == cur,
                                  "R6", {tag, " stride advance"}, int'(sector_o), cur);
                        end
                    end
                end
            end
        end
        if (ek == 3)                 rq = "R9";
        else if (tc_pos >= 0 && ek == 2 && n <= tc_pos + 1) rq = "R8";
        else if (ek == 2)            rq = "R7";
        else                         rq = "R5";
        check(done_o && !busy_o, rq, {tag, " done pulse"}, int'(done_o), 1);
        check(scan_hit_o == (ek == 1 && hx), rq, {tag, " R2 R3 scan-hit flag"},
              int'(scan_hit_o), int'(ek == 1 && hx));
        check(scan_nosat_o == (ek == 2), rq, {tag, " not-satisfied flag"},
              int'(scan_nosat_o), int'(ek == 2));
        check(abort_o == (ek == 3), rq, {tag, " abort flag"}, int'(abort_o), int'(ek == 3));
        check(int'(sector_o) == cur, rq, {tag, " final sector"}, int'(sector_o), cur);
        @(negedge clk);
        check(!done_o && !busy_o && scan_nosat_o == (ek == 2) && int'(sector_o) == cur,
              "R10", {tag, " result held"}, int'(sector_o), cur);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [4:0] codes [6];
        codes[0] = 5'h11; codes[1] = 5'h19; codes[2] = 5'h1D;
        codes[3] = 5'h01; codes[4] = 5'h09; codes[5] = 5'h0D;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !scan_hit_o && !scan_nosat_o && !abort_o && sector_o == '0,
              "R1", "reset state", int'(busy_o), 0);
        for (int c = 0; c < 6; c++)
            for (int t = 0; t < 2; t++)
                for (int s = 0; s < 6; s++)
                    run_case(codes[c], 1 + s, 6 + s, t[0], s, -1, 0, -1, 0, "R2 sweep");
        for (int s = 0; s < 6; s++) begin
            run_case(5'h11, 3, 9, 0, s, 3,  0, -1, 0, "R8 tc mid");
            run_case(5'h19, 3, 9, 0, s, 7,  0, -1, 0, "R8 tc last");
            run_case(5'h1D, 3, 9, 1, s, 12, 0, -1, 0, "R8 tc later");
            run_case(5'h1D, 3, 9, 0, s, 9,  1, -1, 0, "R8 tc alone");
        end
        run_case(5'h11, 2, 20, 0, 1, -1, 0, 0,  0, "R9 index first");
        run_case(5'h19, 2, 20, 1, 5, -1, 0, 10, 0, "R9 index later");
        run_case(5'h11, 4, 4,  0, 1, -1, 0, -1, 0, "R7 single sector");
        run_case(5'h1D, 5, 6,  1, 5, -1, 0, -1, 0, "R7 stride overshoot");
        run_case(5'h11, 1, 9,  0, 0, -1, 0, -1, 1, "R11 restart probe");
        run_case(5'h19, 1, 9,  1, 4, -1, 0, -1, 1, "R11 restart probe");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule